// File: doc/BRIEF.md
# Decode-Stage Operand Bypass and Hazard Stall Unit

This block sits beside the decode stage of a five-stage in-order pipeline made of fetch, decode, execute, memory and writeback. For each of the two source operands of the instruction in decode, it chooses where the value should come from. The choices are the register-file read data, which was started in fetch, or a result still held in the execute, memory or writeback stage. The register file takes two cycles to complete a write. A value leaving the memory stage is therefore not yet readable, and the writeback stage has to act as a bypass source as well.

The unit also produces the hold controls for the front of the pipeline. Decode and fetch are held when an operand depends on a load or multicycle result that does not exist yet. In that case a bubble is sent into execute. Fetch, decode and execute are all held while the memory stage waits on an outstanding memory or multicycle operation. The whole unit is combinational. The register storage and the operand multiplexers belong to the datapath.

Top module: `opfwd_unit`

## Requirements
- R1: Select codes are 0 for register file, 1 for execute, 2 for memory and 3 for writeback. An operand that no later stage matches selects code 0.
- R2: An operand whose index equals the execute-stage destination selects code 1 when that stage is valid, writes a register and has kind ALU. Kind codes are 0 ALU, 1 load, 2 multicycle, and 3 is handled like a multicycle operation.
- R3: When several stages match the same operand, the youngest one wins: execute before memory, and memory before writeback.
- R4: A writeback-stage destination that matches an operand, with no younger match, selects code 3.
- R5: A stage is ignored for bypass and stall unless both its valid bit and its register-write bit are set.
- R6: Source index 0 never matches any stage. It selects code 0, raises that operand's zero flag and never causes a stall. A nonzero index keeps the zero flag low.
- R7: If the winning match of an operand is an execute-stage load or multicycle operation, the fetch and decode holds go high, the execute bubble goes high and the execute hold stays low.
- R8: If the winning match of an operand is a memory-stage load or multicycle operation, the same holds and bubble as in R7 apply.
- R9: An older load or multicycle producer that is hidden behind a younger ALU match on the same index causes no stall.
- R10: While the memory stage is valid and busy, the fetch, decode and execute holds are all high and the execute bubble is low, even when a data hazard is present.
- R11: The busy flag has no effect while the memory-stage valid bit is low.
- R12: The two operands are resolved independently. A hazard on either one holds fetch and decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a_i | input | 5 | Decode-stage first source register index |
| dec_src_b_i | input | 5 | Decode-stage second source register index |
| ex_vld_i | input | 1 | Execute stage holds a valid instruction |
| ex_wr_i | input | 1 | Execute-stage instruction writes a register |
| ex_dst_i | input | 5 | Execute-stage destination index |
| ex_kind_i | input | 2 | Execute-stage kind (0 ALU, 1 load, 2 multicycle) |
| mem_vld_i | input | 1 | Memory stage holds a valid instruction |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_dst_i | input | 5 | Memory-stage destination index |
| mem_kind_i | input | 2 | Memory-stage kind (0 ALU, 1 load, 2 multicycle) |
| mem_busy_i | input | 1 | Memory stage is waiting on an outstanding operation |
| wb_vld_i | input | 1 | Writeback stage holds a valid instruction |
| wb_wr_i | input | 1 | Writeback-stage instruction writes a register |
| wb_dst_i | input | 5 | Writeback-stage destination index |
| opa_sel_o | output | 2 | First operand source select |
| opb_sel_o | output | 2 | Second operand source select |
| opa_zero_o | output | 1 | First operand is register 0 and reads as zero |
| opb_zero_o | output | 1 | Second operand is register 0 and reads as zero |
| stall_fetch_o | output | 1 | Hold the fetch stage |
| stall_dec_o | output | 1 | Hold the decode stage |
| stall_exe_o | output | 1 | Hold the execute stage |
| exe_bubble_o | output | 1 | Insert an empty slot into execute |

## Verification
A data hazard and a busy memory stage can occur in the same cycle. Both raise the front holds, but they disagree about execute: the hazard wants a bubble inserted, while the busy memory stage must freeze execute. The stimulus makes this overlap common by drawing destinations from a small index range and raising busy often, and it also provokes the overlap with one directed case. The judgement is that the execute hold wins, the bubble is suppressed, and the bypass selects still follow the youngest match.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_ALU   = 2'd0,
    KIND_LOAD  = 2'd1,
    KIND_MULTI = 2'd2,
    KIND_RSVD  = 2'd3
  } op_kind_e;

  // A producer counts only when it is real and writes a register.
  function automatic logic stage_writes(input logic vld, input logic wr);
    return vld & wr;
  endfunction

  // Results of loads and multicycle ops are not ready while still in flight.
  function automatic logic kind_is_late(input logic [KIND_W-1:0] kind);
    return kind != KIND_ALU;
  endfunction

endpackage

// File: rtl/opfwd_stage.sv
module opfwd_stage
  import opfwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic              vld_i,
  input  logic              wr_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [AW-1:0]     dst_i,
  output logic              en_o,
  output logic              late_o,
  output logic [AW-1:0]     dst_o
);

  assign en_o   = stage_writes(vld_i, wr_i);
  assign late_o = en_o & kind_is_late(kind_i);
  assign dst_o  = dst_i;

endmodule

// File: rtl/opfwd_operand.sv
module opfwd_operand #(
  parameter int AW   = 5,
  parameter int NSTG = 3,
  localparam int SW  = $clog2(NSTG + 1)
) (
  input  logic [AW-1:0]            src_i,
  input  logic [NSTG-1:0]          en_i,    // index 0 is the youngest stage
  input  logic [NSTG-1:0]          late_i,
  input  logic [NSTG-1:0][AW-1:0]  dst_i,
  output logic [SW-1:0]            sel_o,
  output logic                     zero_o,
  output logic                     hazard_o
);

  logic            nonzero;
  logic [NSTG-1:0] hit;

  assign nonzero = |src_i;
  assign zero_o  = ~nonzero;

  always_comb begin
    for (int j = 0; j < NSTG; j++) begin
      hit[j] = nonzero & en_i[j] & (dst_i[j] == src_i);
    end
  end

  // Walk from oldest to youngest so the youngest hit overwrites.
  always_comb begin
    sel_o    = '0;
    hazard_o = 1'b0;
    for (int j = NSTG - 1; j >= 0; j--) begin
      if (hit[j]) begin
        sel_o    = SW'(j + 1);
        hazard_o = late_i[j];
      end
    end
  end

  always_comb begin
    if (zero_o) begin
      p_zero_src_r6: assert (sel_o == '0 && !hazard_o)
        else $error("register 0 operand bypassed or stalled");
    end
    if (hazard_o) begin
      p_hazard_has_src_r7: assert (sel_o != '0)
        else $error("hazard without a matching producer");
    end
  end

endmodule

// File: rtl/opfwd_hold.sv
module opfwd_hold #(
  parameter int NOPS = 2
) (
  input  logic [NOPS-1:0] hazard_i,
  input  logic            mem_vld_i,
  input  logic            mem_busy_i,
  output logic            stall_f_o,
  output logic            stall_d_o,
  output logic            stall_e_o,
  output logic            bubble_o
);

  logic any_hazard;
  logic mem_hold;

  assign any_hazard = |hazard_i;
  assign mem_hold   = mem_vld_i & mem_busy_i;

  assign stall_f_o  = any_hazard | mem_hold;
  assign stall_d_o  = any_hazard | mem_hold;
  assign stall_e_o  = mem_hold;
  // A frozen execute stage cannot take a bubble.
  assign bubble_o   = any_hazard & ~mem_hold;

endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
  import opfwd_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS),
  localparam int NSTG = 3,
  localparam int NOPS = 2,
  localparam int SW   = $clog2(NSTG + 1)
) (
  input  logic [AW-1:0]     dec_src_a_i,
  input  logic [AW-1:0]     dec_src_b_i,
  input  logic              ex_vld_i,
  input  logic              ex_wr_i,
  input  logic [AW-1:0]     ex_dst_i,
  input  logic [KIND_W-1:0] ex_kind_i,
  input  logic              mem_vld_i,
  input  logic              mem_wr_i,
  input  logic [AW-1:0]     mem_dst_i,
  input  logic [KIND_W-1:0] mem_kind_i,
  input  logic              mem_busy_i,
  input  logic              wb_vld_i,
  input  logic              wb_wr_i,
  input  logic [AW-1:0]     wb_dst_i,
  output logic [SW-1:0]     opa_sel_o,
  output logic [SW-1:0]     opb_sel_o,
  output logic              opa_zero_o,
  output logic              opb_zero_o,
  output logic              stall_fetch_o,
  output logic              stall_dec_o,
  output logic              stall_exe_o,
  output logic              exe_bubble_o
);

  // Stage order: 0 execute, 1 memory, 2 writeback (youngest first).
  logic [NSTG-1:0]              st_vld, st_wr, st_en, st_late;
  logic [NSTG-1:0][AW-1:0]      st_dst_in, st_dst;
  logic [NSTG-1:0][KIND_W-1:0]  st_kind;

  assign st_vld    = {wb_vld_i, mem_vld_i, ex_vld_i};
  assign st_wr     = {wb_wr_i, mem_wr_i, ex_wr_i};
  assign st_dst_in = {wb_dst_i, mem_dst_i, ex_dst_i};
  assign st_kind   = {KIND_ALU, mem_kind_i, ex_kind_i};

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    opfwd_stage #(.AW(AW)) u_stage (
      .vld_i  (st_vld[s]),
      .wr_i   (st_wr[s]),
      .kind_i (st_kind[s]),
      .dst_i  (st_dst_in[s]),
      .en_o   (st_en[s]),
      .late_o (st_late[s]),
      .dst_o  (st_dst[s])
    );
  end

  logic [NOPS-1:0][AW-1:0] op_src;
  logic [NOPS-1:0][SW-1:0] op_sel;
  logic [NOPS-1:0]         op_zero;
  logic [NOPS-1:0]         op_hazard;

  assign op_src = {dec_src_b_i, dec_src_a_i};

  for (genvar g = 0; g < NOPS; g++) begin : g_operand
    opfwd_operand #(.AW(AW), .NSTG(NSTG)) u_operand (
      .src_i    (op_src[g]),
      .en_i     (st_en),
      .late_i   (st_late),
      .dst_i    (st_dst),
      .sel_o    (op_sel[g]),
      .zero_o   (op_zero[g]),
      .hazard_o (op_hazard[g])
    );
  end

  assign opa_sel_o  = op_sel[0];
  assign opb_sel_o  = op_sel[1];
  assign opa_zero_o = op_zero[0];
  assign opb_zero_o = op_zero[1];

  opfwd_hold #(.NOPS(NOPS)) u_hold (
    .hazard_i   (op_hazard),
    .mem_vld_i  (mem_vld_i),
    .mem_busy_i (mem_busy_i),
    .stall_f_o  (stall_fetch_o),
    .stall_d_o  (stall_dec_o),
    .stall_e_o  (stall_exe_o),
    .bubble_o   (exe_bubble_o)
  );

  always_comb begin
    if (mem_vld_i && mem_busy_i) begin
      p_busy_freeze_r10: assert (stall_fetch_o && stall_dec_o && stall_exe_o && !exe_bubble_o)
        else $error("busy memory stage did not freeze the front");
    end
    if (!mem_vld_i) begin
      p_idle_busy_r11: assert (!stall_exe_o)
        else $error("execute held without a valid memory stage");
    end
    if (|op_hazard) begin
      p_either_hazard_r12: assert (stall_fetch_o && stall_dec_o)
        else $error("operand hazard did not hold the front");
    end
    if (ex_vld_i && ex_wr_i && dec_src_a_i != '0 && ex_dst_i == dec_src_a_i) begin
      p_exec_first_r3: assert (opa_sel_o == SW'(1))
        else $error("execute match did not win");
    end
  end

endmodule

// File: tb/opfwd_unit_bench.sv
`timescale 1ns/1ps
module opfwd_unit_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] sa, sb, exd, memd, wbd;
  logic       exv, exw, mv, mw, mb, wv, ww;
  logic [1:0] exk, mk;

  logic [1:0] sel_a, sel_b;
  logic       z_a, z_b, st_f, st_d, st_e, bub;

  int  nchk = 0;
  int  nbad = 0;
  bit  done = 0;

  opfwd_unit u_opfwd_unit (
    .dec_src_a_i   (sa),
    .dec_src_b_i   (sb),
    .ex_vld_i      (exv),
    .ex_wr_i       (exw),
    .ex_dst_i      (exd),
    .ex_kind_i     (exk),
    .mem_vld_i     (mv),
    .mem_wr_i      (mw),
    .mem_dst_i     (memd),
    .mem_kind_i    (mk),
    .mem_busy_i    (mb),
    .wb_vld_i      (wv),
    .wb_wr_i       (ww),
    .wb_dst_i      (wbd),
    .opa_sel_o     (sel_a),
    .opb_sel_o     (sel_b),
    .opa_zero_o    (z_a),
    .opb_zero_o    (z_b),
    .stall_fetch_o (st_f),
    .stall_dec_o   (st_d),
    .stall_exe_o   (st_e),
    .exe_bubble_o  (bub)
  );

  // Bench model: pick the youngest qualified producer by explicit checks.
  function automatic void model(input logic [4:0] s, output logic [1:0] sel,
                                output logic zf, output logic late);
    sel = 2'd0; late = 1'b0; zf = (s == 5'd0);
    if (!zf) begin
      if (exv && exw && exd == s) begin
        sel = 2'd1; late = (exk != 2'd0);
      end else if (mv && mw && memd == s) begin
        sel = 2'd2; late = (mk != 2'd0);
      end else if (wv && ww && wbd == s) begin
        sel = 2'd3;
      end
    end
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    sa = 0; sb = 0; exd = 0; memd = 0; wbd = 0;
    exv = 0; exw = 0; mv = 0; mw = 0; mb = 0; wv = 0; ww = 0;
    exk = 0; mk = 0;
  endtask

  task automatic check_all(input string req);
    logic [1:0] es_a, es_b;
    logic ez_a, ez_b, el_a, el_b, hz, busy;
    #1;
    model(sa, es_a, ez_a, el_a);
    model(sb, es_b, ez_b, el_b);
    hz   = el_a | el_b;
    busy = mv & mb;
    chk(req, "sel_a", 32'(sel_a), 32'(es_a));
    chk(req, "sel_b", 32'(sel_b), 32'(es_b));
    chk(req, "zero_a", 32'(z_a), 32'(ez_a));
    chk(req, "zero_b", 32'(z_b), 32'(ez_b));
    chk(req, "stall_f", 32'(st_f), 32'(hz | busy));
    chk(req, "stall_d", 32'(st_d), 32'(hz | busy));
    chk(req, "stall_e", 32'(st_e), 32'(busy));
    chk(req, "bubble", 32'(bub), 32'(hz & ~busy));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog all requirements actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: idle pipeline, everything from register file, no holds.
    @(negedge clk); clear_inputs(); sa = 5; sb = 9;
    check_all("R1 idle");
    chk("R1", "idle sel_a literal", 32'(sel_a), 0);

    // R2: execute ALU match.
    @(negedge clk); clear_inputs(); sa = 7; exv = 1; exw = 1; exd = 7;
    check_all("R2");
    chk("R2", "ex sel literal", 32'(sel_a), 1);

    // R3: all three match, then memory and writeback only.
    @(negedge clk); clear_inputs(); sb = 4;
    exv = 1; exw = 1; exd = 4; mv = 1; mw = 1; memd = 4; wv = 1; ww = 1; wbd = 4;
    check_all("R3 all");
    chk("R3", "youngest literal", 32'(sel_b), 1);
    @(negedge clk); exv = 0;
    check_all("R3 mem over wb");
    chk("R3", "mem literal", 32'(sel_b), 2);

    // R4: writeback only.
    @(negedge clk); clear_inputs(); sa = 12; wv = 1; ww = 1; wbd = 12;
    check_all("R4");
    chk("R4", "wb literal", 32'(sel_a), 3);

    // R5: valid without write, write without valid.
    @(negedge clk); clear_inputs(); sa = 3; exv = 1; exw = 0; exd = 3; exk = 1;
    check_all("R5 no write");
    chk("R5", "no-write stall", 32'(st_d), 0);
    @(negedge clk); clear_inputs(); sa = 3; mv = 0; mw = 1; memd = 3; mk = 2;
    check_all("R5 not valid");
    chk("R5", "invalid sel", 32'(sel_a), 0);

    // R6: index 0 against long producers writing 0.
    @(negedge clk); clear_inputs(); sa = 0; sb = 0;
    exv = 1; exw = 1; exd = 0; exk = 1; mv = 1; mw = 1; memd = 0; mk = 2;
    check_all("R6");
    chk("R6", "zero flag literal", 32'(z_a), 1);
    chk("R6", "zero no stall", 32'(st_d), 0);

    // R7: execute load hazard on operand b.
    @(negedge clk); clear_inputs(); sb = 20; exv = 1; exw = 1; exd = 20; exk = 1;
    check_all("R7");
    chk("R7", "bubble literal", 32'(bub), 1);
    chk("R7", "exe not held", 32'(st_e), 0);

    // R8: memory multicycle hazard, and reserved kind.
    @(negedge clk); clear_inputs(); sa = 17; mv = 1; mw = 1; memd = 17; mk = 2;
    check_all("R8");
    chk("R8", "stall literal", 32'(st_f), 1);
    @(negedge clk); mk = 3;
    check_all("R8 kind3");

    // R9: younger ALU hides older load.
    @(negedge clk); clear_inputs(); sa = 6;
    exv = 1; exw = 1; exd = 6; exk = 0; mv = 1; mw = 1; memd = 6; mk = 1;
    check_all("R9");
    chk("R9", "shadowed no stall", 32'(st_d), 0);

    // R10: busy alone, and busy together with a hazard.
    @(negedge clk); clear_inputs(); mv = 1; mb = 1;
    check_all("R10 busy");
    @(negedge clk); sa = 8; exv = 1; exw = 1; exd = 8; exk = 2;
    check_all("R10 busy+hazard");
    chk("R10", "bubble suppressed", 32'(bub), 0);
    chk("R10", "exe held", 32'(st_e), 1);

    // R11: busy without a valid memory stage.
    @(negedge clk); clear_inputs(); mv = 0; mb = 1;
    check_all("R11");
    chk("R11", "no hold", 32'(st_e), 0);

    // R12: independent operands.
    @(negedge clk); clear_inputs(); sa = 2; sb = 3;
    exv = 1; exw = 1; exd = 2; mv = 1; mw = 1; memd = 3; mk = 1;
    check_all("R12");
    chk("R12", "a from ex", 32'(sel_a), 1);
    chk("R12", "b hazard stall", 32'(st_d), 1);

    // Random mix over a small index range to force overlaps.
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      sa   = 5'($urandom_range(0, 3));
      sb   = 5'($urandom_range(0, 3));
      exd  = 5'($urandom_range(0, 3));
      memd = 5'($urandom_range(0, 3));
      wbd  = 5'($urandom_range(0, 3));
      exv  = 1'($urandom_range(0, 1));
      exw  = 1'($urandom_range(0, 3) != 0);
      mv   = 1'($urandom_range(0, 1));
      mw   = 1'($urandom_range(0, 3) != 0);
      mb   = 1'($urandom_range(0, 2) == 0);
      wv   = 1'($urandom_range(0, 1));
      ww   = 1'($urandom_range(0, 3) != 0);
      exk  = 2'($urandom_range(0, 3));
      mk   = 2'($urandom_range(0, 3));
      check_all("random R3 R7 R8 R10 R12");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule